// File: doc/BRIEF.md
# Serial Configuration Register Port

This block accepts an 8-bit control word over a four-wire serial port and keeps it in a configuration register. The port has an active-low select, a direction line (0 selects a write, 1 a read), a serial clock and a serial data line. All four lines are brought into the system clock domain through a synchronizer. Data bits are sampled on rising serial-clock edges into a shadow register while a write frame is open. The shadow is copied to the active register when the select line returns high at the end of that frame.

The stored word is split into named control fields: power-down, calibration request, use-offset enable, channel select, a reserved bit, and a 3-bit decimation-rate code. A mode input chooses the source of the control outputs. When the mode input is low, the outputs come from the register. When it is high, they come straight from a set of dedicated control pins. A write whose bit count is not eight, or whose reserved bit is high, is still committed as received but raises an error flag. The flag exists so that a faulty configuration sequence is visible in simulation.

Top module: `scfg_port`

## Requirements
- R1: While rst_n is low at a clock edge, the register and the error flag clear to zero. With mode_hw low, every control output then reads 0.
- R2: The first bit shifted in is power_down, then cal_req, use_offset, chan_sel, the reserved bit, and finally decimation bits 2, 1 and 0. Register bit 7 is power_down and bit 0 is dec_rate[0].
- R3: The register changes only when a write frame ends. During a frame, the outputs keep the previous word.
- R4: A frame in which rd_wr stays high (a read) changes neither the register nor wr_err.
- R5: With mode_hw high, each control output equals its matching pin_* input. With mode_hw low, each output equals its register field.
- R6: Writes made while mode_hw is high still load the register. The new word appears on the outputs once mode_hw returns low.
- R7: A write that ends after a bit count other than 8 sets wr_err. The register takes the last bits received, with the newest bit in bit 0 and zeros above them when fewer than 8 bits arrived.
- R8: A write of exactly 8 bits with the reserved bit (register bit 3) high still loads every field and sets wr_err.
- R9: A write of exactly 8 bits with the reserved bit low clears wr_err.
- R10: A write frame with no serial-clock edges at all still commits: the register becomes all zeros and wr_err is set.
- R11: Serial-clock edges while ser_sel_n is high shift nothing into the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_sel_n | input | 1 | Serial port select, active low |
| rd_wr | input | 1 | Frame direction, 0 = write, 1 = read |
| ser_clk | input | 1 | Serial clock; data sampled on its rising edge |
| ser_din | input | 1 | Serial data in, first bit = register bit 7 |
| mode_hw | input | 1 | 1 = outputs from pins, 0 = outputs from register |
| pin_power_down | input | 1 | Hardware-mode power-down control |
| pin_cal_req | input | 1 | Hardware-mode calibration request |
| pin_use_offset | input | 1 | Hardware-mode use-offset enable |
| pin_chan_sel | input | 1 | Hardware-mode channel select |
| pin_dec_rate | input | 3 | Hardware-mode decimation code |
| power_down | output | 1 | Power-down control |
| cal_req | output | 1 | Calibration request |
| use_offset | output | 1 | Use-offset enable |
| chan_sel | output | 1 | Channel select |
| dec_rate | output | 3 | Decimation-rate code |
| wr_err | output | 1 | Last write ended with a bad bit count or the reserved bit high |

## Verification
The bound checker checks the following on every clock:
- the mode multiplexer follows its selected source;
- the register stays put between frame ends;
- the committed word equals the shadow;
- the error flag follows the bit count and the reserved bit at each commit.

Only the bench's serial frames can show the end-to-end properties: the MSB-first field mapping, truncation of long or short writes, that read frames and idle clock edges have no effect, and that writes made in hardware mode surface later. The bench checks these at the ports against a bench-side model of the register.

// File: rtl/scfg_pkg.sv
// Shared types for the serial configuration port.
// Assumes the word layout below; packed order equals the shift order (first bit = MSB).
package scfg_pkg;
    typedef struct packed {
        logic       power_down;
        logic       cal_req;
        logic       use_offset;
        logic       chan_sel;
        logic       rsvd;
        logic [2:0] dec_rate;
    } ctrl_word_t;

    localparam int WORD_W   = $bits(ctrl_word_t);
    localparam int CNT_W    = $clog2(WORD_W) + 2;
    localparam int RSVD_BIT = 3;
endpackage

// File: rtl/scfg_sync.sv
// Multi-bit level synchronizer: STAGES flops per bit, reset to RST_VAL.
// Assumes each bit is an independent slow level; no bus coherence is implied.
module scfg_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/scfg_frame_ctl.sv
// Frame control: detects serial-clock rising edges and select release.
// Commit is issued at select release only when the frame contained a write phase.
// Assumes synchronized inputs.
module scfg_frame_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic s_sel_n,
    input  logic s_rd,
    input  logic s_clk,
    output logic shift_en,
    output logic frame_idle,
    output logic commit
);
    logic p_sel_n;
    logic p_clk;
    logic wr_seen;
    logic wr_phase;

    assign wr_phase   = !s_sel_n && !s_rd;
    assign frame_idle = s_sel_n;
    assign shift_en   = wr_phase && s_clk && !p_clk;
    assign commit     = s_sel_n && !p_sel_n && wr_seen;

    // Keep previous samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_sel_n <= 1'b1;
            p_clk   <= 1'b0;
        end else begin
            p_sel_n <= s_sel_n;
            p_clk   <= s_clk;
        end
    end

    // Remember whether the open frame had any write phase.
    always_ff @(posedge clk) begin
        if (!rst_n)         wr_seen <= 1'b0;
        else if (s_sel_n)   wr_seen <= 1'b0;
        else if (wr_phase)  wr_seen <= 1'b1;
    end
endmodule

// File: rtl/scfg_shifter.sv
// Shadow shift register and saturating bit counter.
// Both clear while the port is idle, so stray clocks never carry into a frame.
module scfg_shifter
    import scfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_idle,
    input  logic              shift_en,
    input  logic              din,
    output logic [WORD_W-1:0] shadow,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Shift new bits in at bit 0, so the first bit ends at the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_idle) shadow <= '0;
        else if (shift_en)        shadow <= {shadow[WORD_W-2:0], din};
    end

    // Count received bits, saturating so overlong frames stay detectable.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_idle)            bit_cnt <= '0;
        else if (shift_en && bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
endmodule

// File: rtl/scfg_store.sv
// Active configuration register and write error flag.
// Loads the shadow unconditionally on commit; the flag records a bad count or reserved bit.
module scfg_store
    import scfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [WORD_W-1:0] shadow,
    input  logic [CNT_W-1:0]  bit_cnt,
    output ctrl_word_t        active,
    output logic              wr_err
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    // Copy the shadow into the register at the end of a write frame.
    always_ff @(posedge clk) begin
        if (!rst_n)      active <= '0;
        else if (commit) active <= ctrl_word_t'(shadow);
    end

    // Flag writes with a wrong length or a set reserved bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_err <= 1'b0;
        else if (commit) wr_err <= (bit_cnt != FULL) || shadow[RSVD_BIT];
    end
endmodule

// File: rtl/scfg_out_mux.sv
// Control-output source select: pins in hardware mode, register otherwise.
// The reserved field is forced to zero on the output side.
module scfg_out_mux
    import scfg_pkg::*;
(
    input  logic       mode_hw,
    input  ctrl_word_t reg_word,
    input  ctrl_word_t pin_word,
    output ctrl_word_t out_word
);
    // Pick the control source and mask the reserved field.
    always_comb begin
        out_word      = mode_hw ? pin_word : reg_word;
        out_word.rsvd = 1'b0;
    end
endmodule

// File: rtl/scfg_port.sv
// Top level of the serial configuration port.
// Assumes the serial lines are slow relative to clk (several clk per serial level).
module scfg_port
    import scfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_sel_n,
    input  logic       rd_wr,
    input  logic       ser_clk,
    input  logic       ser_din,
    input  logic       mode_hw,
    input  logic       pin_power_down,
    input  logic       pin_cal_req,
    input  logic       pin_use_offset,
    input  logic       pin_chan_sel,
    input  logic [2:0] pin_dec_rate,
    output logic       power_down,
    output logic       cal_req,
    output logic       use_offset,
    output logic       chan_sel,
    output logic [2:0] dec_rate,
    output logic       wr_err
);
    logic [3:0]        s_bus;
    logic              shift_en;
    logic              frame_idle;
    logic              commit;
    logic [WORD_W-1:0] shadow;
    logic [CNT_W-1:0]  bit_cnt;
    ctrl_word_t        active;
    ctrl_word_t        pin_word;
    ctrl_word_t        out_word;

    scfg_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_sel_n, rd_wr, ser_clk, ser_din}),
        .q     (s_bus)
    );

    scfg_frame_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_sel_n    (s_bus[3]),
        .s_rd       (s_bus[2]),
        .s_clk      (s_bus[1]),
        .shift_en   (shift_en),
        .frame_idle (frame_idle),
        .commit     (commit)
    );

    scfg_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_idle (frame_idle),
        .shift_en   (shift_en),
        .din        (s_bus[0]),
        .shadow     (shadow),
        .bit_cnt    (bit_cnt)
    );

    scfg_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .shadow  (shadow),
        .bit_cnt (bit_cnt),
        .active  (active),
        .wr_err  (wr_err)
    );

    assign pin_word = '{power_down: pin_power_down, cal_req: pin_cal_req,
                        use_offset: pin_use_offset, chan_sel: pin_chan_sel,
                        rsvd: 1'b0, dec_rate: pin_dec_rate};

    scfg_out_mux u_mux (
        .mode_hw  (mode_hw),
        .reg_word (active),
        .pin_word (pin_word),
        .out_word (out_word)
    );

    assign power_down = out_word.power_down;
    assign cal_req    = out_word.cal_req;
    assign use_offset = out_word.use_offset;
    assign chan_sel   = out_word.chan_sel;
    assign dec_rate   = out_word.dec_rate;
endmodule

// File: rtl/scfg_port_chk.sv
// Checker for scfg_port, attached by bind; observes ports and inter-module signals.
module scfg_port_chk
    import scfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mode_hw,
    input logic [6:0]        pins,
    input logic [6:0]        outs,
    input logic              wr_err,
    input logic              commit,
    input logic [WORD_W-1:0] shadow,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [WORD_W-1:0] active_w
);
    logic       seen_edge;
    logic       rst_prev;
    logic [6:0] reg_fields;

    assign reg_fields = {active_w[7:4], active_w[2:0]};

    // Track the previous reset level once a clock edge has occurred.
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
        rst_prev  <= rst_n;
        if (seen_edge === 1'b1 && rst_prev === 1'b0) begin
            a_r1_reset_clears: assert (active_w == '0 && wr_err == 1'b0);
        end
    end

    a_r3_hold_between_commits: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active_w));

    a_r7_commit_loads_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> active_w == $past(shadow));

    a_r5_hw_follows_pins: assert property (@(posedge clk) disable iff (!rst_n)
        mode_hw |-> outs == pins);

    a_r5_sw_follows_reg: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_hw |-> outs == reg_fields);

    a_r7_bad_count_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && bit_cnt != CNT_W'(WORD_W)) |=> wr_err);

    a_r8_rsvd_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && shadow[RSVD_BIT]) |=> wr_err);

    a_r9_clean_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && bit_cnt == CNT_W'(WORD_W) && !shadow[RSVD_BIT]) |=> !wr_err);
endmodule

bind scfg_port scfg_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_hw  (mode_hw),
    .pins     ({pin_power_down, pin_cal_req, pin_use_offset, pin_chan_sel, pin_dec_rate}),
    .outs     ({power_down, cal_req, use_offset, chan_sel, dec_rate}),
    .wr_err   (wr_err),
    .commit   (commit),
    .shadow   (shadow),
    .bit_cnt  (bit_cnt),
    .active_w (active)
);

// File: tb/tb_scfg_port.sv
`timescale 1ns/1ps
module tb_scfg_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_sel_n = 1'b1, rd_wr = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
    logic       mode_hw = 1'b0;
    logic       pin_power_down = 0, pin_cal_req = 0, pin_use_offset = 0, pin_chan_sel = 0;
    logic [2:0] pin_dec_rate = '0;
    logic       power_down, cal_req, use_offset, chan_sel, wr_err;
    logic [2:0] dec_rate;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_reg = '0;
    logic       m_err = 1'b0;

    always #4 clk = ~clk;

    scfg_port dut (
        .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n), .rd_wr(rd_wr),
        .ser_clk(ser_clk), .ser_din(ser_din), .mode_hw(mode_hw),
        .pin_power_down(pin_power_down), .pin_cal_req(pin_cal_req),
        .pin_use_offset(pin_use_offset), .pin_chan_sel(pin_chan_sel),
        .pin_dec_rate(pin_dec_rate), .power_down(power_down), .cal_req(cal_req),
        .use_offset(use_offset), .chan_sel(chan_sel), .dec_rate(dec_rate),
        .wr_err(wr_err)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected outputs {pd,cal,uo,ch,dec[2:0]} from the mode and the model register.
    function automatic logic [6:0] exp_outs();
        if (mode_hw) return {pin_power_down, pin_cal_req, pin_use_offset, pin_chan_sel, pin_dec_rate};
        return {m_reg[7:4], m_reg[2:0]};
    endfunction

    // Register value after a write of n bits of v (first bit = v[n-1]).
    function automatic logic [7:0] exp_word(input int n, input logic [31:0] v);
        logic [31:0] m;
        m = (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
        return 8'(v & m);
    endfunction

    task automatic check_outs(input string req);
        logic [6:0] act;
        logic [6:0] exp;
        act = {power_down, cal_req, use_offset, chan_sel, dec_rate};
        exp = exp_outs();
        checks++;
        if (act !== exp || wr_err !== m_err) begin
            errors++;
            $display("FAIL %s: outs=%b err=%b expected outs=%b err=%b", req, act, wr_err, exp, m_err);
        end
    endtask

    // One serial frame of n bits of v; rd selects a read frame.
    task automatic ser_frame(input int n, input logic [31:0] v, input logic rd);
        rd_wr = rd;
        ser_sel_n = 1'b0;
        wait_clk(3);
        for (int i = n - 1; i >= 0; i--) begin
            ser_din = v[i];
            ser_clk = 1'b0;
            wait_clk(3);
            ser_clk = 1'b1;
            wait_clk(3);
        end
        ser_clk = 1'b0;
        wait_clk(6);
        check_outs("R3 mid-frame hold");
        ser_sel_n = 1'b1;
        wait_clk(2);
        rd_wr = 1'b1;
        if (!rd) begin
            m_reg = exp_word(n, v);
            m_err = (n != 8) || m_reg[3];
        end
        wait_clk(6);
    endtask

    initial begin
        wait_clk(150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5CF6));
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        check_outs("R1 reset state");

        ser_frame(8, 32'hA5 & ~32'h08, 1'b0);
        check_outs("R2 field mapping 0xA5-rsvd");
        ser_frame(8, 32'h81, 1'b0);
        check_outs("R2 power_down and dec_rate[0]");
        ser_frame(8, 32'h5A, 1'b0);
        check_outs("R8 reserved bit high");
        ser_frame(8, 32'h46, 1'b0);
        check_outs("R9 clean write clears error");
        ser_frame(8, 32'hFF, 1'b1);
        check_outs("R4 read frame no effect");
        ser_frame(5, 32'h17, 1'b0);
        check_outs("R7 short write");
        ser_frame(11, 32'h6B7, 1'b0);
        check_outs("R7 long write");
        ser_frame(0, 32'h0, 1'b0);
        check_outs("R10 write without clocks");

        // R11: idle clock edges must not leak into the next frame.
        for (int k = 0; k < 3; k++) begin
            ser_din = 1'b1; ser_clk = 1'b1; wait_clk(3); ser_clk = 1'b0; wait_clk(3);
        end
        ser_frame(8, 32'h22, 1'b0);
        check_outs("R11 idle clocks ignored");

        // R5/R6: write while pins drive the outputs, then return to register mode.
        mode_hw = 1'b1;
        {pin_power_down, pin_cal_req, pin_use_offset, pin_chan_sel, pin_dec_rate} = 7'b1010_110;
        wait_clk(1);
        check_outs("R5 hardware mode pins");
        ser_frame(8, 32'hF7, 1'b0);
        check_outs("R6 write in hardware mode");
        mode_hw = 1'b0;
        wait_clk(1);
        check_outs("R6 word appears in software mode");

        for (int k = 0; k < 40; k++) begin
            int n;
            logic rd;
            n  = ($urandom % 4 == 0) ? int'($urandom % 13) : 8;
            rd = ($urandom % 6 == 0);
            mode_hw = $urandom % 3 == 0;
            {pin_power_down, pin_cal_req, pin_use_offset, pin_chan_sel, pin_dec_rate} = 7'($urandom);
            ser_frame(n, $urandom, rd);
            check_outs("R2 R4 R5 R7 random frame");
        end

        rst_n = 1'b0;
        wait_clk(2);
        rst_n = 1'b1;
        mode_hw = 1'b0;
        m_reg = '0;
        m_err = 1'b0;
        wait_clk(1);
        check_outs("R1 reset after traffic");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule